// File: doc/BRIEF.md
# Configurable True Dual-Port SRAM

This block holds a pool of 8,192 bits that two independent ports can each read and write. Each port runs on its own clock. A width parameter sets each port's data width to 1, 2, 4, 8 or 16 bits. The address width follows from that choice: the log2 of the total bit count divided by the width, which gives 13 bits down to 9 bits. A word of width W at address A covers pool bits A*W through A*W+W-1. A narrow port and a wide port therefore see the same bits in the same order. For example, with a 4-bit port and a 16-bit port, nibble j of 16-bit word k is 4-bit address 4k+j.

Each port captures its request in a small state register on the port clock. The request is made of address, write data, read/write select and a two-bit chip select. The register has three states:

- `PS_IDLE` means no request is held.
- `PS_READ` means a read is held.
- `PS_WRITE` means a write is held and waits for its commit edge.

The transitions are:

- **capture**: on any edge with clock enable active, the next state is `PS_WRITE` or `PS_READ` when both chip-select bits are 1, and `PS_IDLE` otherwise.
- **commit**: on an edge with clock enable inactive, `PS_WRITE` moves to `PS_READ`, and the write is stored on that same edge.
- **hold**: on an edge with clock enable inactive, `PS_READ` and `PS_IDLE` stay where they are.

A write also commits on the edge that follows its capture when the clock enable stays active. Each port's read data can be combinational from the pool or registered on a separate output clock. The input side and the output side of each port each have their own clock, enable and reset, and a polarity parameter can invert any of them. Each effective reset is the OR of a global reset and the port's own reset.

Top module: `tdp_sram`

## Requirements
- R1: Port data of width W at address A occupies pool bits A*W to A*W+W-1. With a 4-bit port A and a 16-bit port B, port A address 4k+j is bits [4j+3:4j] of port B word k.
- R2: A request is accepted only when both chip-select bits are 1 (cs == 2'b11) at a capture edge with clock enable active. Otherwise the port goes to `PS_IDLE`, stores nothing, and its combinational read data is 0.
- R3: Address, write data, read/write select and chip select are registered on the port clock. A captured write is stored in the pool at the next port clock edge.
- R4: While clock enable is inactive, the port's input registers hold their values. A held write commits exactly once, and the port then reads back the held address.
- R5: In combinational output mode, read data shows the pool bits at the registered address while the port holds a read or a write. It is 0 in `PS_IDLE`.
- R6: In registered output mode, the output register loads the pool bits at the registered address on an output-clock edge when the output enable is active and the port holds a request. Otherwise it keeps its value.
- R7: A port that writes a location sees that location's previous contents on its read data during the cycle the write is pending.
- R8: When both ports commit writes to overlapping bits on the same edge, port A's data is stored for the overlap. The non-overlapping bits of both writes are stored.
- R9: Each reset is asynchronous. The input reset of a port is the global reset OR the port reset, and it returns the state to `PS_IDLE` with the address and data registers at 0. The output reset is the global reset OR the port output reset, and it clears the output register. No reset alters the pool contents.
- R10: Each port has a 6-bit polarity parameter. When a bit is set, the matching pin is inverted: bit 0 input clock, bit 1 clock enable, bit 2 input reset, bit 3 output clock, bit 4 output enable, bit 5 output reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_all | input | 1 | Global asynchronous reset, active high |
| a_clk | input | 1 | Port A input clock |
| a_ce | input | 1 | Port A clock enable |
| a_rst | input | 1 | Port A input reset |
| a_oclk | input | 1 | Port A output clock |
| a_oce | input | 1 | Port A output enable |
| a_orst | input | 1 | Port A output reset |
| a_addr | input | A_AW | Port A address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_we | input | 1 | Port A write select (1 = write) |
| a_cs | input | 2 | Port A chip select, both bits needed |
| a_rdata | output | A_WIDTH | Port A read data |
| b_clk | input | 1 | Port B input clock |
| b_ce | input | 1 | Port B clock enable |
| b_rst | input | 1 | Port B input reset |
| b_oclk | input | 1 | Port B output clock |
| b_oce | input | 1 | Port B output enable |
| b_orst | input | 1 | Port B output reset |
| b_addr | input | B_AW | Port B address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_we | input | 1 | Port B write select (1 = write) |
| b_cs | input | 2 | Port B chip select, both bits needed |
| b_rdata | output | B_WIDTH | Port B read data |

## Verification
The embedded assertions watch the per-port request register on every cycle. They check that a deselected capture lands in `PS_IDLE`, that the input registers keep their values while the enable is inactive, and that a held write leaves `PS_WRITE` after one commit. They also check that the registered output keeps its value when it may not load. The remaining behaviours appear only in the bench scenarios, where a behavioural model of the pool is compared with both ports on every clock:

- the mapping between a 4-bit and a 16-bit view of the same bits;
- old data seen during a pending same-port write;
- port A winning a same-edge collision;
- chip-select patterns that leave the pool unchanged;
- resets that clear the ports but leave the pool contents in place.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;

    localparam int WORD_BITS = 16;

    localparam int POL_CLK  = 0;
    localparam int POL_CE   = 1;
    localparam int POL_RST  = 2;
    localparam int POL_OCLK = 3;
    localparam int POL_OCE  = 4;
    localparam int POL_ORST = 5;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_READ  = 2'd1,
        PS_WRITE = 2'd2
    } port_state_t;

endpackage

// File: rtl/dpram_port_in.sv
`timescale 1ns/1ps
module dpram_port_in
    import dpram_pkg::*;
#(
    parameter int W  = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          ce,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  logic          we,
    input  logic [1:0]    cs,
    output port_state_t   state,
    output logic [AW-1:0] addr_q,
    output logic [W-1:0]  wdata_q
);

    port_state_t state_d;

    // state register
    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= PS_IDLE;
        else     state <= state_d;
    end

    // next state: capture, commit, hold
    always_comb begin
        state_d = state;
        if (ce) begin
            if (cs == 2'b11) state_d = we ? PS_WRITE : PS_READ;
            else             state_d = PS_IDLE;
        end else begin
            unique case (state)
                PS_WRITE: state_d = PS_READ;
                PS_READ:  state_d = PS_READ;
                PS_IDLE:  state_d = PS_IDLE;
                default:  state_d = PS_IDLE;
            endcase
        end
    end

    // request data registers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (ce) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // R2: a capture without both select bits leaves the port idle
    a_r2_deselect_idle: assert property (@(posedge clk) disable iff (rst)
        (ce && cs != 2'b11) |=> (state == PS_IDLE))
        else $error("R2: deselected capture did not idle");

    // R4: inputs held while enable inactive
    a_r4_hold_inputs: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(addr_q) && $stable(wdata_q)))
        else $error("R4: input registers moved with enable low");

    // R4: a held write commits once, then reads back
    a_r4_write_once: assert property (@(posedge clk) disable iff (rst)
        (!ce && state == PS_WRITE) |=> (state == PS_READ))
        else $error("R4: held write did not turn into a read");

endmodule

// File: rtl/dpram_xor_array.sv
`timescale 1ns/1ps
module dpram_xor_array
    import dpram_pkg::*;
#(
    parameter int TOTAL_BITS = 8192,
    parameter int WA  = 16,
    parameter int WB  = 16,
    parameter int AWA = 9,
    parameter int AWB = 9
) (
    input  logic           clk_a,
    input  logic           wr_a,
    input  logic [AWA-1:0] addr_a,
    input  logic [WA-1:0]  wdata_a,
    output logic [WA-1:0]  rd_a,
    input  logic           clk_b,
    input  logic           wr_b,
    input  logic [AWB-1:0] addr_b,
    input  logic [WB-1:0]  wdata_b,
    output logic [WB-1:0]  rd_b
);

    localparam int WORDS   = TOTAL_BITS / WORD_BITS;
    localparam int IW      = $clog2(WORDS);
    localparam int LANES_A = WORD_BITS / WA;
    localparam int LANES_B = WORD_BITS / WB;

    // each bank is written by one clock only; stored value = bank_a ^ bank_b
    logic [WORD_BITS-1:0] bank_a [WORDS];
    logic [WORD_BITS-1:0] bank_b [WORDS];

    logic [IW-1:0]        wi_a, wi_b;
    int                   off_a, off_b;
    logic [WORD_BITS-1:0] mask_a, mask_b, mask_b_eff;
    logic [WORD_BITS-1:0] sh_a, sh_b, word_a, word_b;

    always_comb begin
        wi_a   = IW'(int'(addr_a) / LANES_A);
        wi_b   = IW'(int'(addr_b) / LANES_B);
        off_a  = (int'(addr_a) % LANES_A) * WA;
        off_b  = (int'(addr_b) % LANES_B) * WB;
        mask_a = WORD_BITS'({WA{1'b1}}) << off_a;
        mask_b = WORD_BITS'({WB{1'b1}}) << off_b;
        sh_a   = WORD_BITS'(wdata_a) << off_a;
        sh_b   = WORD_BITS'(wdata_b) << off_b;
        // port A keeps the overlap on a same-edge collision
        mask_b_eff = mask_b & ~((wr_a && (wi_a == wi_b)) ? mask_a : '0);
        word_a = bank_a[wi_a] ^ bank_b[wi_a];
        word_b = bank_a[wi_b] ^ bank_b[wi_b];
        rd_a   = WA'(word_a >> off_a);
        rd_b   = WB'(word_b >> off_b);
    end

    always_ff @(posedge clk_a) begin
        if (wr_a)
            bank_a[wi_a] <= (bank_a[wi_a] & ~mask_a) | ((sh_a ^ bank_b[wi_a]) & mask_a);
    end

    always_ff @(posedge clk_b) begin
        if (wr_b)
            bank_b[wi_b] <= (bank_b[wi_b] & ~mask_b_eff) | ((sh_b ^ bank_a[wi_b]) & mask_b_eff);
    end

endmodule

// File: rtl/dpram_port_out.sv
`timescale 1ns/1ps
module dpram_port_out #(
    parameter int W    = 16,
    parameter bit OREG = 1'b0
) (
    input  logic         oclk,
    input  logic         oce,
    input  logic         orst,
    input  logic         valid,
    input  logic [W-1:0] rd_data,
    output logic [W-1:0] rdata
);

    generate
        if (OREG) begin : g_reg
            logic [W-1:0] q;
            always_ff @(posedge oclk or posedge orst) begin
                if (orst)              q <= '0;
                else if (oce && valid) q <= rd_data;
            end
            assign rdata = q;

            // R6: output register keeps its value when it may not load
            a_r6_oreg_hold: assert property (@(posedge oclk) disable iff (orst)
                !(oce && valid) |=> $stable(rdata))
                else $error("R6: output register changed without a load");
        end else begin : g_comb
            logic unused_ctl;
            assign unused_ctl = oclk ^ oce ^ orst;
            assign rdata = valid ? rd_data : '0;
        end
    endgenerate

endmodule

// File: rtl/tdp_sram.sv
`timescale 1ns/1ps
module tdp_sram
    import dpram_pkg::*;
#(
    parameter int         TOTAL_BITS = 8192,
    parameter int         A_WIDTH    = 16,
    parameter int         B_WIDTH    = 16,
    parameter bit         A_OREG     = 1'b0,
    parameter bit         B_OREG     = 1'b0,
    parameter logic [5:0] A_POL      = 6'b000000,
    parameter logic [5:0] B_POL      = 6'b000000,
    localparam int        A_AW       = $clog2(TOTAL_BITS / A_WIDTH),
    localparam int        B_AW       = $clog2(TOTAL_BITS / B_WIDTH)
) (
    input  logic               rst_all,
    input  logic               a_clk,
    input  logic               a_ce,
    input  logic               a_rst,
    input  logic               a_oclk,
    input  logic               a_oce,
    input  logic               a_orst,
    input  logic [A_AW-1:0]    a_addr,
    input  logic [A_WIDTH-1:0] a_wdata,
    input  logic               a_we,
    input  logic [1:0]         a_cs,
    output logic [A_WIDTH-1:0] a_rdata,
    input  logic               b_clk,
    input  logic               b_ce,
    input  logic               b_rst,
    input  logic               b_oclk,
    input  logic               b_oce,
    input  logic               b_orst,
    input  logic [B_AW-1:0]    b_addr,
    input  logic [B_WIDTH-1:0] b_wdata,
    input  logic               b_we,
    input  logic [1:0]         b_cs,
    output logic [B_WIDTH-1:0] b_rdata
);

    // polarity resolution (R10) and reset merge (R9)
    logic a_clk_i, a_ce_i, a_rst_i, a_oclk_i, a_oce_i, a_orst_i;
    logic b_clk_i, b_ce_i, b_rst_i, b_oclk_i, b_oce_i, b_orst_i;

    assign a_clk_i  = a_clk  ^ A_POL[POL_CLK];
    assign a_ce_i   = a_ce   ^ A_POL[POL_CE];
    assign a_rst_i  = rst_all | (a_rst  ^ A_POL[POL_RST]);
    assign a_oclk_i = a_oclk ^ A_POL[POL_OCLK];
    assign a_oce_i  = a_oce  ^ A_POL[POL_OCE];
    assign a_orst_i = rst_all | (a_orst ^ A_POL[POL_ORST]);

    assign b_clk_i  = b_clk  ^ B_POL[POL_CLK];
    assign b_ce_i   = b_ce   ^ B_POL[POL_CE];
    assign b_rst_i  = rst_all | (b_rst  ^ B_POL[POL_RST]);
    assign b_oclk_i = b_oclk ^ B_POL[POL_OCLK];
    assign b_oce_i  = b_oce  ^ B_POL[POL_OCE];
    assign b_orst_i = rst_all | (b_orst ^ B_POL[POL_ORST]);

    port_state_t        a_state, b_state;
    logic [A_AW-1:0]    a_addr_q;
    logic [B_AW-1:0]    b_addr_q;
    logic [A_WIDTH-1:0] a_wdata_q, a_rd;
    logic [B_WIDTH-1:0] b_wdata_q, b_rd;

    dpram_port_in #(.W(A_WIDTH), .AW(A_AW)) u_in_a (
        .clk(a_clk_i), .ce(a_ce_i), .rst(a_rst_i),
        .addr(a_addr), .wdata(a_wdata), .we(a_we), .cs(a_cs),
        .state(a_state), .addr_q(a_addr_q), .wdata_q(a_wdata_q)
    );

    dpram_port_in #(.W(B_WIDTH), .AW(B_AW)) u_in_b (
        .clk(b_clk_i), .ce(b_ce_i), .rst(b_rst_i),
        .addr(b_addr), .wdata(b_wdata), .we(b_we), .cs(b_cs),
        .state(b_state), .addr_q(b_addr_q), .wdata_q(b_wdata_q)
    );

    dpram_xor_array #(
        .TOTAL_BITS(TOTAL_BITS), .WA(A_WIDTH), .WB(B_WIDTH), .AWA(A_AW), .AWB(B_AW)
    ) u_array (
        .clk_a(a_clk_i), .wr_a(a_state == PS_WRITE), .addr_a(a_addr_q),
        .wdata_a(a_wdata_q), .rd_a(a_rd),
        .clk_b(b_clk_i), .wr_b(b_state == PS_WRITE), .addr_b(b_addr_q),
        .wdata_b(b_wdata_q), .rd_b(b_rd)
    );

    dpram_port_out #(.W(A_WIDTH), .OREG(A_OREG)) u_out_a (
        .oclk(a_oclk_i), .oce(a_oce_i), .orst(a_orst_i),
        .valid(a_state != PS_IDLE), .rd_data(a_rd), .rdata(a_rdata)
    );

    dpram_port_out #(.W(B_WIDTH), .OREG(B_OREG)) u_out_b (
        .oclk(b_oclk_i), .oce(b_oce_i), .orst(b_orst_i),
        .valid(b_state != PS_IDLE), .rd_data(b_rd), .rdata(b_rdata)
    );

endmodule

// File: tb/sim_tdp_sram.sv
`timescale 1ns/1ps
module sim_tdp_sram;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_all;
    logic        a_ce_n, a_rst;
    logic [10:0] a_addr;
    logic [3:0]  a_wd;
    logic        a_we;
    logic [1:0]  a_cs;
    logic [3:0]  a_rdata;
    logic        b_ce, b_rst_n, b_oce;
    logic [8:0]  b_addr;
    logic [15:0] b_wd;
    logic        b_we;
    logic [1:0]  b_cs;
    logic [15:0] b_rdata;

    // port A: 4 bits, combinational out, enable inverted (R10)
    // port B: 16 bits, registered out, both resets inverted (R10)
    tdp_sram #(
        .TOTAL_BITS(8192), .A_WIDTH(4), .B_WIDTH(16),
        .A_OREG(1'b0), .B_OREG(1'b1),
        .A_POL(6'b000010), .B_POL(6'b100100)
    ) u0 (
        .rst_all(rst_all),
        .a_clk(clk), .a_ce(a_ce_n), .a_rst(a_rst),
        .a_oclk(clk), .a_oce(1'b0), .a_orst(1'b0),
        .a_addr(a_addr), .a_wdata(a_wd), .a_we(a_we), .a_cs(a_cs), .a_rdata(a_rdata),
        .b_clk(clk), .b_ce(b_ce), .b_rst(b_rst_n),
        .b_oclk(clk), .b_oce(b_oce), .b_orst(b_rst_n),
        .b_addr(b_addr), .b_wdata(b_wd), .b_we(b_we), .b_cs(b_cs), .b_rdata(b_rdata)
    );

    // behavioural reference
    logic [15:0] mref [512];
    int          sa, sb, ma_addr, mb_addr;
    logic [3:0]  ma_wd;
    logic [15:0] mb_wd, outb;
    int          total = 0, fails = 0;
    bit          done = 0;

    task automatic model_edge();
        bit ra, rb;
        ra = rst_all || a_rst;
        rb = rst_all || !b_rst_n;
        if (ra) begin sa = 0; ma_addr = 0; ma_wd = '0; end
        if (rb) begin sb = 0; mb_addr = 0; mb_wd = '0; outb = '0; end
        if (!rb && b_oce && sb != 0) outb = mref[mb_addr];
        if (sb == 2) mref[mb_addr] = mb_wd;
        if (sa == 2) mref[ma_addr / 4][(ma_addr % 4) * 4 +: 4] = ma_wd; // A wins
        if (!ra) begin
            if (!a_ce_n) begin
                sa = (a_cs == 2'b11) ? (a_we ? 2 : 1) : 0;
                ma_addr = int'(a_addr); ma_wd = a_wd;
            end else if (sa == 2) sa = 1;
        end
        if (!rb) begin
            if (b_ce) begin
                sb = (b_cs == 2'b11) ? (b_we ? 2 : 1) : 0;
                mb_addr = int'(b_addr); mb_wd = b_wd;
            end else if (sb == 2) sb = 1;
        end
    endtask

    task automatic check_outs(input string tag);
        logic [3:0] ea;
        ea = (sa != 0) ? mref[ma_addr / 4][(ma_addr % 4) * 4 +: 4] : 4'h0;
        total++;
        if (a_rdata !== ea) begin
            fails++;
            $display("FAIL %s port A rdata=%h expected=%h", tag, a_rdata, ea);
        end
        total++;
        if (b_rdata !== outb) begin
            fails++;
            $display("FAIL %s port B rdata=%h expected=%h", tag, b_rdata, outb);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outs(tag);
    endtask

    task automatic set_a(input logic [1:0] cs, input logic we, input int addr, input logic [3:0] d);
        a_cs = cs; a_we = we; a_addr = 11'(addr); a_wd = d;
    endtask

    task automatic set_b(input logic [1:0] cs, input logic we, input int addr, input logic [15:0] d);
        b_cs = cs; b_we = we; b_addr = 9'(addr); b_wd = d;
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'(i * 40503) ^ 16'h3C5A;
    endfunction

    initial begin
        foreach (mref[i]) mref[i] = '0;
        sa = 0; sb = 0; ma_addr = 0; mb_addr = 0; ma_wd = '0; mb_wd = '0; outb = '0;
        rst_all = 1'b1; a_rst = 1'b0; b_rst_n = 1'b1;
        a_ce_n = 1'b0; b_ce = 1'b1; b_oce = 1'b0;
        set_a(2'b00, 1'b0, 0, 4'h0);
        set_b(2'b00, 1'b0, 0, 16'h0);
        tick("R9 reset state");
        tick("R9 reset state");
        rst_all = 1'b0;
        tick("R5 idle reads zero");

        // fill pool from port B (output enable low during fill)
        for (int i = 0; i < 512; i++) begin
            set_b(2'b11, 1'b1, i, pat(i));
            tick("R3 fill");
        end
        set_b(2'b00, 1'b0, 0, 16'h0);
        tick("R3 fill end");
        b_oce = 1'b1;

        // narrow view of the wide data
        for (int i = 0; i < 2048; i++) begin
            set_a(2'b11, 1'b0, i, 4'h0);
            tick("R1 R5 narrow read");
        end
        // wide registered reads
        for (int i = 0; i < 64; i++) begin
            set_b(2'b11, 1'b0, i * 7 % 512, 16'h0);
            tick("R6 wide read");
        end

        // narrow writes, read-old during pending write, wide readback
        for (int k = 0; k < 32; k++) begin
            set_a(2'b11, 1'b1, k * 4 + (k % 4), 4'(k) ^ 4'hA);
            tick("R3 R7 narrow write");
            set_a(2'b11, 1'b0, k * 4 + (k % 4), 4'h0);
            tick("R7 narrow readback");
        end
        set_a(2'b00, 1'b0, 0, 4'h0);
        for (int k = 0; k < 32; k++) begin
            set_b(2'b11, 1'b0, k, 16'h0);
            tick("R1 wide view");
        end

        // same-edge collisions: A wins overlap
        for (int k = 40; k < 48; k++) begin
            set_a(2'b11, 1'b1, k * 4 + 1, 4'(k));
            set_b(2'b11, 1'b1, k, ~pat(k));
            tick("R8 collide");
        end
        set_a(2'b00, 1'b0, 0, 4'h0);
        for (int k = 40; k < 49; k++) begin
            set_b(2'b11, 1'b0, k, 16'h0);
            tick("R8 collide readback");
        end

        // partial chip select stores nothing
        set_a(2'b01, 1'b1, 8, 4'h5);
        set_b(2'b10, 1'b1, 3, 16'hDEAD);
        tick("R2 partial select");
        set_a(2'b10, 1'b1, 9, 4'h6);
        set_b(2'b01, 1'b1, 4, 16'hBEEF);
        tick("R2 partial select");
        set_a(2'b11, 1'b0, 8, 4'h0);
        set_b(2'b11, 1'b0, 3, 16'h0);
        tick("R2 readback");
        set_a(2'b11, 1'b0, 9, 4'h0);
        set_b(2'b11, 1'b0, 4, 16'h0);
        tick("R2 readback");
        tick("R2 readback");

        // enable inactive: held write commits once, inputs ignored
        set_a(2'b11, 1'b1, 100, 4'h3);
        tick("R4 capture write");
        a_ce_n = 1'b1;
        set_a(2'b11, 1'b1, 200, 4'hC);
        tick("R4 hold commit");
        tick("R4 hold");
        set_a(2'b00, 1'b0, 300, 4'h0);
        tick("R4 hold");
        a_ce_n = 1'b0;
        set_a(2'b11, 1'b0, 200, 4'h0);
        tick("R4 untouched address");

        // output enable low holds registered output
        set_b(2'b11, 1'b0, 25, 16'h0);
        tick("R6 load");
        tick("R6 load");
        b_oce = 1'b0;
        set_b(2'b11, 1'b0, 26, 16'h0);
        tick("R6 hold");
        tick("R6 hold");
        b_oce = 1'b1;
        tick("R6 reload");

        // port A reset alone
        set_a(2'b11, 1'b1, 60, 4'h9);
        tick("R9 pending write");
        a_rst = 1'b1;
        tick("R9 port reset");
        tick("R9 port reset");
        a_rst = 1'b0;
        set_a(2'b11, 1'b0, 60, 4'h0);
        tick("R9 after port reset");

        // port B reset, active low through polarity
        b_rst_n = 1'b0;
        tick("R10 inverted reset");
        tick("R10 inverted reset");
        b_rst_n = 1'b1;
        set_b(2'b11, 1'b0, 15, 16'h0);
        tick("R10 after reset");
        tick("R10 after reset");

        // global reset keeps pool
        set_b(2'b11, 1'b1, 77, 16'h1234);
        set_a(2'b11, 1'b1, 5, 4'h7);
        tick("R9 pending");
        rst_all = 1'b1;
        tick("R9 global reset");
        rst_all = 1'b0;
        for (int k = 0; k < 16; k++) begin
            set_a(2'b11, 1'b0, k, 4'h0);
            set_b(2'b11, 1'b0, 70 + k, 16'h0);
            tick("R9 pool kept");
        end

        // mixed stimulus around a small window
        for (int n = 0; n < 600; n++) begin
            a_ce_n = ($urandom_range(0, 4) == 0);
            b_ce   = ($urandom_range(0, 4) != 0);
            b_oce  = ($urandom_range(0, 3) != 0);
            set_a(2'($urandom_range(0, 3) == 0 ? $urandom_range(0, 2) : 3),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 63)), 4'($urandom));
            set_b(2'($urandom_range(0, 3) == 0 ? $urandom_range(0, 2) : 3),
                  1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), 16'($urandom));
            tick("R8 mixed");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog run did not finish expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule